// File: doc/BRIEF.md
# Character-Granular Raster Timing Generator

This block produces the horizontal sync, vertical sync, composite sync and display-enable strobes for a progressive-scan raster. It also reports the current pixel column and line. It runs on the pixel clock. Horizontal timing is held in character units of eight pixels. A pixel counter inside the character lets the leading edge of horizontal sync be placed to the exact pixel.

Software programs the timing through a register-write port made of five 32-bit words: a control word, two horizontal words and two vertical words. Each write goes into a shadow copy. The whole set moves into the active copy on the clock edge where the raster wraps back to its first pixel, so a frame is always produced with one coherent timing set. Sync polarity and composite-sync behaviour come from bits inside these words.

Top module: `chr_timing_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the shadow word picked by `wr_sel`: 0 = control, 1 = horizontal total/display, 2 = horizontal sync, 3 = vertical total/display, 4 = vertical sync. Select codes 5 to 7, and any cycle with `wr_en` low, leave every timing word unchanged.
- R2: Shadow words reach the active set only on the edge where the raster wraps to column 0, line 0. A write made during a frame does not alter the rest of that frame. The next frame uses the new set from its first pixel.
- R3: The horizontal total/display word holds (characters per line − 1) in bits 8:0. The vertical total/display word holds (lines per frame − 1) in bits 10:0. `col` counts 0 to 8·(htotal+1)−1 and advances by one each clock. `row` advances when `col` wraps and returns to 0 after the last line. All outputs are registered: they describe the raster position one clock after the counters reach it.
- R4: `de` is high only when col/8 ≤ hdisplay and row ≤ vdisplay. hdisplay is bits 24:16 of the horizontal total/display word; vdisplay is bits 26:16 of the vertical total/display word.
- R5: The horizontal sync word gives a pixel delay in bits 2:0, a start character in bits 11:3 and a width in characters in bits 21:16. Horizontal sync is active for pixels P with S ≤ P < S + 8·width, where S = 8·start + delay. The window is cut off at the end of the line.
- R6: A sync width field of zero is treated as one: one character for horizontal sync, one line for vertical sync.
- R7: The vertical sync word gives a start line in bits 10:0 and a width in lines in bits 20:16. Vertical sync is active on lines L with start ≤ L < start + width. The window is cut off at the end of the frame.
- R8: Bit 23 of each sync word sets polarity. A 1 makes that sync output active-low; a 0 makes it active-high.
- R9: Control bit 4 enables composite sync. Control bit 5 makes it active-low. When enabled, `csync` is active whenever horizontal or vertical sync is active. When disabled, `csync` stays at its inactive level.
- R10: While `rst` is high, all outputs are 0 and both shadow and active words load the reset parameter values. The first clock after `rst` falls shows column 0, line 0 of a frame built from those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Timing word write strobe |
| wr_sel | input | 3 | Timing word select |
| wr_data | input | 32 | Timing word write data |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| csync | output | 1 | Composite sync |
| de | output | 1 | Display enable |
| col | output | 12 | Current pixel column |
| row | output | 11 | Current line |

## Verification
The bench sweeps whole frames for several timing sets. These include a horizontal sync window that runs past the end of the line, a vertical window that runs past the end of the frame, zero-width sync fields, both polarities, and a one-character, one-line raster where every strobe stays active. A design that compared only the character count would place the sync edge up to seven pixels early. One that did not treat a zero width as one would lose the pulse entirely. A timing set is rewritten in the middle of a frame: copying shadows at once would bend that frame's line length and show up as a position mismatch. Writes with unused select codes or with the strobe low must leave the next frame identical, which catches a loose address decode.

// File: rtl/chr_tg_pkg.sv
package chr_tg_pkg;

  localparam int PIX_W  = 3;
  localparam int HC_W   = 9;
  localparam int VL_W   = 11;
  localparam int HSW_W  = 6;
  localparam int VSW_W  = 5;
  localparam int WORD_W = 32;
  localparam int NWORDS = 5;
  localparam int SEL_W  = 3;
  localparam int COL_W  = HC_W + PIX_W;

  // word indices, equal to the write select codes
  localparam int IDX_CTL = 0;
  localparam int IDX_HTD = 1;
  localparam int IDX_HSS = 2;
  localparam int IDX_VTD = 3;
  localparam int IDX_VSS = 4;

  // field positions
  localparam int CTL_CS_EN  = 4;
  localparam int CTL_CS_LOW = 5;
  localparam int POL_BIT    = 23;
  localparam int UPPER_LSB  = 16;
  localparam int HSTART_LSB = PIX_W;

  typedef struct packed {
    logic             cs_en;
    logic             cs_low;
    logic [HC_W-1:0]  h_total;
    logic [HC_W-1:0]  h_disp;
    logic [HC_W-1:0]  h_start;
    logic [PIX_W-1:0] h_dly;
    logic [HSW_W-1:0] h_wid;
    logic             h_low;
    logic [VL_W-1:0]  v_total;
    logic [VL_W-1:0]  v_disp;
    logic [VL_W-1:0]  v_start;
    logic [VSW_W-1:0] v_wid;
    logic             v_low;
  } tg_cfg_t;

  function automatic tg_cfg_t unpack_cfg(input logic [NWORDS*WORD_W-1:0] w);
    tg_cfg_t c;
    logic [WORD_W-1:0] ctl, htd, hss, vtd, vss;
    ctl = w[IDX_CTL*WORD_W +: WORD_W];
    htd = w[IDX_HTD*WORD_W +: WORD_W];
    hss = w[IDX_HSS*WORD_W +: WORD_W];
    vtd = w[IDX_VTD*WORD_W +: WORD_W];
    vss = w[IDX_VSS*WORD_W +: WORD_W];
    c.cs_en   = ctl[CTL_CS_EN];
    c.cs_low  = ctl[CTL_CS_LOW];
    c.h_total = htd[HC_W-1:0];
    c.h_disp  = htd[UPPER_LSB +: HC_W];
    c.h_dly   = hss[PIX_W-1:0];
    c.h_start = hss[HSTART_LSB +: HC_W];
    c.h_wid   = hss[UPPER_LSB +: HSW_W];
    c.h_low   = hss[POL_BIT];
    c.v_total = vtd[VL_W-1:0];
    c.v_disp  = vtd[UPPER_LSB +: VL_W];
    c.v_start = vss[VL_W-1:0];
    c.v_wid   = vss[UPPER_LSB +: VSW_W];
    c.v_low   = vss[POL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/chr_tg_regs.sv
module chr_tg_regs
  import chr_tg_pkg::*;
#(
  parameter logic [WORD_W-1:0] P_CTL_INIT = '0,
  parameter logic [WORD_W-1:0] P_HTD_INIT = '0,
  parameter logic [WORD_W-1:0] P_HSS_INIT = 32'h0001_0000,
  parameter logic [WORD_W-1:0] P_VTD_INIT = '0,
  parameter logic [WORD_W-1:0] P_VSS_INIT = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_wrap,
  output tg_cfg_t           cfg
);

  localparam logic [NWORDS*WORD_W-1:0] INIT_FLAT =
    {P_VSS_INIT, P_VTD_INIT, P_HSS_INIT, P_HTD_INIT, P_CTL_INIT};

  logic [NWORDS*WORD_W-1:0] active_flat;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] active_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= INIT_FLAT[gi*WORD_W +: WORD_W];
        active_q <= INIT_FLAT[gi*WORD_W +: WORD_W];
      end else begin
        if (wr_en && (wr_sel == SEL_W'(gi)))
          shadow_q <= wr_data;
        // a write on the wrap edge lands in the shadow only
        if (frame_wrap)
          active_q <= shadow_q;
      end
    end

    assign active_flat[gi*WORD_W +: WORD_W] = active_q;
  end

  assign cfg = unpack_cfg(active_flat);

endmodule

// File: rtl/chr_tg_count.sv
module chr_tg_count #(
  parameter int PIX_W = 3,
  parameter int HC_W  = 9,
  parameter int VL_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HC_W-1:0]  h_total,
  input  logic [VL_W-1:0]  v_total,
  output logic [PIX_W-1:0] pix_q,
  output logic [HC_W-1:0]  ch_q,
  output logic [VL_W-1:0]  ln_q,
  output logic             frame_wrap
);

  logic char_end, line_end;

  assign char_end   = (pix_q == {PIX_W{1'b1}});
  assign line_end   = char_end && (ch_q == h_total);
  assign frame_wrap = line_end && (ln_q == v_total);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
      ch_q  <= '0;
      ln_q  <= '0;
    end else begin
      pix_q <= pix_q + 1'b1;
      if (line_end) begin
        ch_q <= '0;
        ln_q <= frame_wrap ? '0 : ln_q + 1'b1;
      end else if (char_end) begin
        ch_q <= ch_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/chr_tg_span.sv
module chr_tg_span #(
  parameter int POS_W = 12,
  parameter int LEN_W = 9
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] start,
  input  logic [LEN_W-1:0] len,
  output logic             hit
);

  logic [POS_W:0] stop;

  assign stop = {1'b0, start} + {{(POS_W+1-LEN_W){1'b0}}, len};
  assign hit  = ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < stop);

endmodule

// File: rtl/chr_tg_decode.sv
module chr_tg_decode
  import chr_tg_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [HC_W-1:0]  ch,
  input  logic [VL_W-1:0]  ln,
  input  tg_cfg_t          cfg,
  output logic             hs_lvl,
  output logic             vs_lvl,
  output logic             cs_lvl,
  output logic             de_lvl
);

  localparam int HLEN_W = HSW_W + PIX_W;

  logic [HSW_W-1:0]  h_wid_eff;
  logic [VSW_W-1:0]  v_wid_eff;
  logic [COL_W-1:0]  h_pos, h_first;
  logic [HLEN_W-1:0] h_len;
  logic              hs_on, vs_on;

  assign h_wid_eff = (cfg.h_wid == '0) ? HSW_W'(1) : cfg.h_wid;
  assign v_wid_eff = (cfg.v_wid == '0) ? VSW_W'(1) : cfg.v_wid;

  assign h_pos   = {ch, pix};
  assign h_first = {cfg.h_start, cfg.h_dly};
  assign h_len   = {h_wid_eff, {PIX_W{1'b0}}};

  chr_tg_span #(.POS_W(COL_W), .LEN_W(HLEN_W)) u_hspan (
    .pos(h_pos), .start(h_first), .len(h_len), .hit(hs_on)
  );

  chr_tg_span #(.POS_W(VL_W), .LEN_W(VSW_W)) u_vspan (
    .pos(ln), .start(cfg.v_start), .len(v_wid_eff), .hit(vs_on)
  );

  assign hs_lvl = hs_on ^ cfg.h_low;
  assign vs_lvl = vs_on ^ cfg.v_low;
  assign cs_lvl = cfg.cs_en ? ((hs_on | vs_on) ^ cfg.cs_low) : cfg.cs_low;
  assign de_lvl = (ch <= cfg.h_disp) && (ln <= cfg.v_disp);

endmodule

// File: rtl/chr_timing_gen.sv
module chr_timing_gen
  import chr_tg_pkg::*;
#(
  parameter logic [WORD_W-1:0] P_CTL_INIT = 32'h0000_0000,
  parameter logic [WORD_W-1:0] P_HTD_INIT = 32'h004F_0063,
  parameter logic [WORD_W-1:0] P_HSS_INIT = 32'h008C_0290,
  parameter logic [WORD_W-1:0] P_VTD_INIT = 32'h01DF_020C,
  parameter logic [WORD_W-1:0] P_VSS_INIT = 32'h0082_01E9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              csync,
  output logic              de,
  output logic [COL_W-1:0]  col,
  output logic [VL_W-1:0]   row
);

  tg_cfg_t          cfg_act;
  logic [PIX_W-1:0] pix_q;
  logic [HC_W-1:0]  ch_q;
  logic [VL_W-1:0]  ln_q;
  logic             frame_wrap;
  logic             hs_lvl, vs_lvl, cs_lvl, de_lvl;

  chr_tg_regs #(
    .P_CTL_INIT(P_CTL_INIT), .P_HTD_INIT(P_HTD_INIT), .P_HSS_INIT(P_HSS_INIT),
    .P_VTD_INIT(P_VTD_INIT), .P_VSS_INIT(P_VSS_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_wrap(frame_wrap), .cfg(cfg_act)
  );

  chr_tg_count #(.PIX_W(PIX_W), .HC_W(HC_W), .VL_W(VL_W)) u_count (
    .clk(clk), .rst(rst), .h_total(cfg_act.h_total), .v_total(cfg_act.v_total),
    .pix_q(pix_q), .ch_q(ch_q), .ln_q(ln_q), .frame_wrap(frame_wrap)
  );

  chr_tg_decode u_decode (
    .pix(pix_q), .ch(ch_q), .ln(ln_q), .cfg(cfg_act),
    .hs_lvl(hs_lvl), .vs_lvl(vs_lvl), .cs_lvl(cs_lvl), .de_lvl(de_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      csync <= 1'b0;
      de    <= 1'b0;
      col   <= '0;
      row   <= '0;
    end else begin
      hsync <= hs_lvl;
      vsync <= vs_lvl;
      csync <= cs_lvl;
      de    <= de_lvl;
      col   <= {ch_q, pix_q};
      row   <= ln_q;
    end
  end

endmodule

// File: rtl/chr_tg_checker.sv
module chr_tg_checker
  import chr_tg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             hsync,
  input logic             vsync,
  input logic             csync,
  input logic             de,
  input logic [COL_W-1:0] col,
  input logic [VL_W-1:0]  row,
  input logic [PIX_W-1:0] pix_q,
  input logic [HC_W-1:0]  ch_q,
  input logic [VL_W-1:0]  ln_q,
  input tg_cfg_t          cfg_act
);

  logic live, rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    live  <= !rst;
  end

  // R10: outputs held at zero after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_q) begin
      a_r10_reset_quiet: assert (!hsync && !vsync && !csync && !de && col == '0 && row == '0)
        else $error("R10 outputs not quiet during reset");
    end
  end

  // R3: pixel position within a character steps by one
  a_r3_pix_step: assert property (@(posedge clk) disable iff (rst)
    (live && col[PIX_W-1:0] != {PIX_W{1'b1}}) |=> (col[PIX_W-1:0] == $past(col[PIX_W-1:0]) + 1'b1));

  // R3: the line number only moves at column zero
  a_r3_row_hold: assert property (@(posedge clk) disable iff (rst)
    (live && $past(live) && col != '0) |-> $stable(row));

  // R3: counters never pass the active totals
  a_r3_ch_bound: assert property (@(posedge clk) disable iff (rst)
    ch_q <= cfg_act.h_total);

  a_r3_ln_bound: assert property (@(posedge clk) disable iff (rst)
    ln_q <= cfg_act.v_total);

  // R2: the active timing set changes only at the first pixel of a frame
  a_r2_cfg_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (live && cfg_act != $past(cfg_act)) |-> (pix_q == '0 && ch_q == '0 && ln_q == '0));

endmodule

bind chr_timing_gen chr_tg_checker u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .csync(csync), .de(de),
  .col(col), .row(row), .pix_q(pix_q), .ch_q(ch_q), .ln_q(ln_q), .cfg_act(cfg_act)
);

// File: tb/test_chr_timing_gen.sv
module test_chr_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] htd;
    logic [31:0] hss;
    logic [31:0] vtd;
    logic [31:0] vss;
    logic [31:0] cyc;  // expected frame length in clocks
    logic [31:0] dep;  // expected display-enable clocks per frame
  } vec_t;

  // 0: 80x12 raster, composite high, delayed hsync edge      (R3 R4 R5 R7 R9)
  // 1: both syncs active-low, zero widths, composite off low (R6 R8 R9)
  // 2: windows cut at line and frame end, composite low      (R5 R7 R8 R9)
  // 3: one character by one line, every strobe always on     (R3 R4 R5 R7)
  localparam vec_t VECS [4] = '{
    '{32'h0000_0010, 32'h0005_0009, 32'h0001_003B, 32'h0007_000B, 32'h0002_0009, 32'd960, 32'd384},
    '{32'h0000_0020, 32'h0003_0005, 32'h0080_0020, 32'h0004_0006, 32'h0080_0005, 32'd336, 32'd160},
    '{32'h0000_0030, 32'h0007_0007, 32'h0003_002F, 32'h0009_0009, 32'h0084_0008, 32'd640, 32'd640},
    '{32'h0000_0010, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 32'd8,   32'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, csync, de;
  logic [11:0] col;
  logic [10:0] row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_timing_gen #(
    .P_CTL_INIT(32'h0000_0010), .P_HTD_INIT(32'h0005_0009), .P_HSS_INIT(32'h0001_003B),
    .P_VTD_INIT(32'h0007_000B), .P_VSS_INIT(32'h0002_0009)
  ) i_chr_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .csync(csync), .de(de), .col(col), .row(row)
  );

  task automatic tally(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input vec_t v, input int i);
    case (i)
      0: return v.ctl;
      1: return v.htd;
      2: return v.hss;
      3: return v.vtd;
      default: return v.vss;
    endcase
  endfunction

  // expected {cs, de, vs, hs} from the field layout of the requirements
  function automatic logic [3:0] expect_sig(input vec_t v, input int c, input int r);
    int hdisp, hst, hdl, hw, vdisp, vst, vw;
    bit hp, vp, ce, cp, ha, va, e;
    hdisp = int'(v.htd[24:16]);
    hst   = int'(v.hss[11:3]);
    hdl   = int'(v.hss[2:0]);
    hw    = int'(v.hss[21:16]);
    hp    = v.hss[23];
    vdisp = int'(v.vtd[26:16]);
    vst   = int'(v.vss[10:0]);
    vw    = int'(v.vss[20:16]);
    vp    = v.vss[23];
    ce    = v.ctl[4];
    cp    = v.ctl[5];
    if (hw == 0) hw = 1;
    if (vw == 0) vw = 1;
    ha = (c >= hst*8 + hdl) && (c < hst*8 + hdl + hw*8);
    va = (r >= vst) && (r < vst + vw);
    e  = ((c / 8) <= hdisp) && (r <= vdisp);
    return {ce ? ((ha | va) ^ cp) : cp, e, va ^ vp, ha ^ hp};
  endfunction

  task automatic wait_frame();
    do @(negedge clk); while (!(col == '0 && row == '0));
  endtask

  task automatic write_cfg(input vec_t v);
    for (int i = 0; i < 5; i++) begin
      wr_en   = 1'b1;
      wr_sel  = 3'(i);
      wr_data = word_of(v, i);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  // called at a negedge where the outputs show column 0, line 0
  task automatic check_frame(input vec_t v, input string tag, input int wr_at, input vec_t nv);
    int e_col, e_row, htot, vtot, dcnt;
    bit [4:0] bad;
    logic [31:0] fa [5];
    logic [31:0] fe [5];
    logic [31:0] act [5];
    logic [31:0] exv [5];
    logic [3:0] ex;
    e_col = 0; e_row = 0; dcnt = 0; bad = '0;
    htot = int'(v.htd[8:0]);
    vtot = int'(v.vtd[10:0]);
    for (int k = 0; k < 5; k++) begin fa[k] = '0; fe[k] = '0; end
    for (int k = 0; k < int'(v.cyc); k++) begin
      ex = expect_sig(v, e_col, e_row);
      act[0] = {4'h0, col, 5'h0, row};
      exv[0] = {4'h0, 12'(e_col), 5'h0, 11'(e_row)};
      act[1] = {31'h0, de};    exv[1] = {31'h0, ex[2]};
      act[2] = {31'h0, hsync}; exv[2] = {31'h0, ex[0]};
      act[3] = {31'h0, vsync}; exv[3] = {31'h0, ex[1]};
      act[4] = {31'h0, csync}; exv[4] = {31'h0, ex[3]};
      for (int s = 0; s < 5; s++) begin
        if (act[s] != exv[s] && !bad[s]) begin
          bad[s] = 1'b1; fa[s] = act[s]; fe[s] = exv[s];
        end
      end
      if (de) dcnt++;
      if (wr_at >= 0 && k >= wr_at && k < wr_at + 5) begin
        wr_en   = 1'b1;
        wr_sel  = 3'(k - wr_at);
        wr_data = word_of(nv, k - wr_at);
      end else begin
        wr_en = 1'b0;
      end
      if (e_col == htot*8 + 7) begin
        e_col = 0;
        e_row = (e_row == vtot) ? 0 : e_row + 1;
      end else begin
        e_col++;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    tally(!bad[0], {tag, " R3 position"}, fa[0], fe[0]);
    tally(!bad[1], {tag, " R4 de"}, fa[1], fe[1]);
    tally(!bad[2], {tag, " R5 R6 R8 hsync"}, fa[2], fe[2]);
    tally(!bad[3], {tag, " R6 R7 R8 vsync"}, fa[3], fe[3]);
    tally(!bad[4], {tag, " R9 csync"}, fa[4], fe[4]);
    tally(col == '0 && row == '0, {tag, " R3 frame length"}, {4'h0, col, 5'h0, row}, 32'h0);
    tally(dcnt == int'(v.dep), {tag, " R4 display count"}, 32'(dcnt), v.dep);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    vec_t junk;
    junk = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0};

    // R10: quiet outputs while reset is held
    rst = 1'b1;
    repeat (4) @(negedge clk);
    tally({hsync, vsync, csync, de} == 4'b0 && col == '0 && row == '0,
          "R10 outputs during reset", {26'h0, hsync, vsync, csync, de, |col, |row}, 32'h0);

    // R10: first frame after release uses the reset parameter words
    rst = 1'b0;
    @(negedge clk);
    check_frame(VECS[0], "R10 reset config", -1, junk);

    // table walk
    for (int i = 0; i < 4; i++) begin
      write_cfg(VECS[i]);
      wait_frame();
      wait_frame();
      check_frame(VECS[i], $sformatf("vec%0d", i), -1, junk);
    end

    // R2: rewrite in mid-frame keeps this frame, switches at the next
    write_cfg(VECS[0]);
    wait_frame();
    wait_frame();
    check_frame(VECS[0], "R2 frame under rewrite", 100, VECS[1]);
    check_frame(VECS[1], "R2 frame after rewrite", -1, junk);

    // R1: unused select codes and a strobe-low cycle change nothing
    for (int s = 5; s < 8; s++) begin
      wr_en = 1'b1; wr_sel = 3'(s); wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_sel = 3'd1; wr_data = 32'h0000_0000;
    @(negedge clk);
    wait_frame();
    wait_frame();
    check_frame(VECS[1], "R1 ignored writes", -1, junk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule